// File: doc/BRIEF.md
# DMA Deferral Controller

This block sits on the device side of a link. It decides when queued DMA transfers may go out to memory. The platform sends a hint that says what its processor is doing: idle in a low-power state, active, or in a window that favours buffer flushes and fills. The hint reaches the device on one of two paths: an in-band message decoder or a sideband wake-pin decoder. A 2-bit enable field picks which path is listened to, and a 2-bit capability field lists which paths the device has.

Requests come in one per cycle on a single port. Each request carries a tag and an urgency bit. Urgent requests are granted at once in every state. While the processor is idle, non-urgent requests are put into a deferral queue. When the hint moves to the window or to active, the queue is drained as a back-to-back batch before any new non-urgent work is taken. If the queue fills while the processor is still idle, the oldest entries are released so that the queue never overflows. Each grant is registered and shows up on the grant outputs one cycle after the decision.

Top module: `dma_defer_ctrl`

## Requirements
- R1: A request with `req_urgent`=1 sees `req_ready`=1 and is granted on the next cycle with `grant_urgent`=1 and its own tag. This holds in every hint state and takes priority over draining the queue.
- R2: With the effective hint active or window and the queue empty, a non-urgent request is accepted and granted on the next cycle with `grant_urgent`=0.
- R3: With the effective hint idle and the queue not full, a non-urgent request is accepted (`req_ready`=1) and stored, and no grant is issued for it.
- R4: With the effective hint idle and the queue full, each cycle without an urgent request grants the oldest queued entry. A non-urgent request offered in that cycle is accepted into the queue.
- R5: While the effective hint is not idle and the queue holds entries, one queued entry is granted per cycle in arrival order. During that drain `req_ready`=0 for non-urgent requests.
- R6: Hint codes are 00 = idle, 01 = active, 10 = flush/fill window. Code 11 is ignored. An accepted hint update takes effect from the cycle after it is presented.
- R7: With `ctl_enable`=01 only `msg_hint_*` updates the hint; with `ctl_enable`=10 only `pin_hint_*` does. Updates on the other path have no effect.
- R8: The hint source is valid only if `ctl_enable` is 01 with `cap_supported`[0]=1, or 10 with `cap_supported`[1]=1. When it is not valid (this includes enable 00 and 11), the block behaves as active in that same cycle and the stored hint returns to active.
- R9: Synchronous active-low reset clears the queue, sets the stored hint to active and drives `grant_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_supported | input | 2 | Hint paths present: bit 0 message, bit 1 wake pin |
| ctl_enable | input | 2 | Hint path select: 00 off, 01 message, 10 wake pin |
| msg_hint_valid | input | 1 | In-band hint update strobe |
| msg_hint | input | 2 | In-band hint code |
| pin_hint_valid | input | 1 | Sideband hint update strobe |
| pin_hint | input | 2 | Sideband hint code |
| req_valid | input | 1 | DMA request offered |
| req_urgent | input | 1 | Request must not be deferred |
| req_tag | input | TAG_W | Request identifier |
| req_ready | output | 1 | Request taken this cycle |
| grant_valid | output | 1 | A transfer is granted |
| grant_tag | output | TAG_W | Tag of the granted transfer |
| grant_urgent | output | 1 | Granted transfer was urgent |

## Verification
The stimulus moves the hint through idle, window and active, and offers urgent, non-urgent and no requests at each point. This separates direct grants from stored entries and from batch drains. Filling the queue while idle is the only way to see the overflow release. Switching to the window while the queue is full shows whether the drain starts in the right cycle and keeps arrival order, and an urgent request dropped into the middle of a drain shows its priority. Updates on the unselected path, reserved codes, disabled enables and unsupported paths are each followed by a request, so any wrong hint change shows up as a grant being present or missing.

// File: rtl/ddc_pkg.sv
// Package: shared codes and types for the DMA deferral controller.
// Assumes 2-bit hint and enable encodings as listed below.
package ddc_pkg;

    // Platform activity hint codes (11 is reserved)
    localparam logic [1:0] HINT_IDLE   = 2'b00;
    localparam logic [1:0] HINT_ACTIVE = 2'b01;
    localparam logic [1:0] HINT_WINDOW = 2'b10;
    localparam logic [1:0] HINT_RSVD   = 2'b11;

    // Hint path select codes
    localparam logic [1:0] SRC_OFF = 2'b00;
    localparam logic [1:0] SRC_MSG = 2'b01;
    localparam logic [1:0] SRC_PIN = 2'b10;

    // Which party supplies the grant this cycle
    typedef enum logic [1:0] {
        SEL_NONE   = 2'b00,
        SEL_URGENT = 2'b01,
        SEL_QUEUE  = 2'b10,
        SEL_DIRECT = 2'b11
    } grant_src_e;

endpackage

// File: rtl/ddc_hint_tracker.sv
// Module: keeps the platform activity hint taken from the selected path.
// The effective hint is forced to active when the path select is off or
// names a path that is not present. Reserved hint codes are dropped.
// Assumes update strobes are already synchronous to clk.
module ddc_hint_tracker
    import ddc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cap_supported,
    input  logic [1:0] ctl_enable,
    input  logic       msg_valid,
    input  logic [1:0] msg_code,
    input  logic       pin_valid,
    input  logic [1:0] pin_code,
    output logic [1:0] eff_hint
);

    logic       use_msg;
    logic       use_pin;
    logic       src_ok;
    logic       upd_valid;
    logic [1:0] upd_code;
    logic [1:0] hint_q;

    // Work out which path (if any) is both selected and present
    always_comb begin
        use_msg = (ctl_enable == SRC_MSG) && cap_supported[0];
        use_pin = (ctl_enable == SRC_PIN) && cap_supported[1];
        src_ok  = use_msg || use_pin;
    end

    // Take the update from the chosen path only
    always_comb begin
        upd_valid = 1'b0;
        upd_code  = HINT_ACTIVE;
        if (use_msg) begin
            upd_valid = msg_valid;
            upd_code  = msg_code;
        end else if (use_pin) begin
            upd_valid = pin_valid;
            upd_code  = pin_code;
        end
    end

    // Store the hint; drop back to active when no valid path exists
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hint_q <= HINT_ACTIVE;
        end else if (!src_ok) begin
            hint_q <= HINT_ACTIVE;
        end else if (upd_valid && (upd_code != HINT_RSVD)) begin
            hint_q <= upd_code;
        end
    end

    // Effective hint seen by the arbiter
    assign eff_hint = src_ok ? hint_q : HINT_ACTIVE;

    // R6
    no_rsvd_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_hint != HINT_RSVD);

    // R7
    msg_quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_enable == SRC_MSG) && cap_supported[0] && !msg_valid &&
         (ctl_enable == $past(ctl_enable)) && ($past(cap_supported[0])))
        |=> (hint_q == $past(hint_q)));

    // R7
    pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_enable == SRC_PIN) && cap_supported[1] && !pin_valid)
        |=> (hint_q == $past(hint_q)) || !rst_n);

    // R8
    bad_src_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |=> (hint_q == HINT_ACTIVE));

endmodule

// File: rtl/ddc_defer_fifo.sv
// Module: first-in first-out store for deferred request tags.
// One push and one pop per cycle, both allowed in the same cycle.
// Assumes DEPTH >= 2 and that the caller never pushes into a full store
// without popping, nor pops an empty one.
module ddc_defer_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    // One storage register per entry, written when the write pointer hits it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == AW'(i))) begin
                slot[i] <= din;
            end
        end
    end

    // Advance pointers with wrap at the last entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = slot[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CMAX);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

    // R9
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> empty);

endmodule

// File: rtl/ddc_grant_arbiter.sv
// Module: picks one grant per cycle from an urgent request, the head of
// the deferral store, or a non-urgent request passed straight through.
// Decides pushes and pops for the store and registers the grant.
// Assumes one request per cycle and a store with same-cycle push and pop.
module ddc_grant_arbiter
    import ddc_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       eff_hint,
    input  logic             req_valid,
    input  logic             req_urgent,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    input  logic             q_empty,
    input  logic             q_full,
    input  logic [TAG_W-1:0] q_head,
    output logic             q_push,
    output logic             q_pop,
    output logic             grant_valid,
    output logic [TAG_W-1:0] grant_tag,
    output logic             grant_urgent
);

    logic       is_idle;
    logic       drain;
    grant_src_e sel;

    // Store is drained when the processor is not idle, or when it is full
    always_comb begin
        is_idle = (eff_hint == HINT_IDLE);
        drain   = !q_empty && (!is_idle || q_full);
    end

    // Grant selection in priority order: urgent, store head, direct
    always_comb begin
        sel       = SEL_NONE;
        req_ready = 1'b0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        if (req_valid && req_urgent) begin
            sel       = SEL_URGENT;
            req_ready = 1'b1;
        end else if (drain) begin
            sel   = SEL_QUEUE;
            q_pop = 1'b1;
            if (is_idle) begin
                req_ready = 1'b1;
                q_push    = req_valid;
            end
        end else if (is_idle) begin
            req_ready = 1'b1;
            q_push    = req_valid;
        end else begin
            req_ready = 1'b1;
            if (req_valid) sel = SEL_DIRECT;
        end
    end

    // Register the chosen grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_tag    <= '0;
            grant_urgent <= 1'b0;
        end else begin
            grant_valid  <= (sel != SEL_NONE);
            grant_urgent <= (sel == SEL_URGENT);
            grant_tag    <= (sel == SEL_QUEUE) ? q_head : req_tag;
        end
    end

    // R1
    urgent_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_urgent) |=> (grant_valid && grant_urgent &&
                                       grant_tag == $past(req_tag)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && !q_full && req_valid && !req_urgent) |=> !grant_valid);

    // R5
    drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_idle && !q_empty && req_valid && !req_urgent) |-> !req_ready);

    // R5
    drain_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_idle && !q_empty && !(req_valid && req_urgent))
        |=> (grant_valid && !grant_urgent));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !grant_valid);

endmodule

// File: rtl/dma_defer_ctrl.sv
// Module: top of the DMA deferral controller. Tracks the platform activity
// hint from the selected path, holds non-urgent requests while idle, and
// releases them in arrival order once the hint allows.
// Assumes all inputs are synchronous to clk.
module dma_defer_ctrl
    import ddc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cap_supported,
    input  logic [1:0]       ctl_enable,
    input  logic             msg_hint_valid,
    input  logic [1:0]       msg_hint,
    input  logic             pin_hint_valid,
    input  logic [1:0]       pin_hint,
    input  logic             req_valid,
    input  logic             req_urgent,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic             grant_valid,
    output logic [TAG_W-1:0] grant_tag,
    output logic             grant_urgent
);

    logic [1:0]       eff_hint;
    logic             q_push;
    logic             q_pop;
    logic             q_empty;
    logic             q_full;
    logic [TAG_W-1:0] q_head;

    ddc_hint_tracker u_hint (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_supported (cap_supported),
        .ctl_enable    (ctl_enable),
        .msg_valid     (msg_hint_valid),
        .msg_code      (msg_hint),
        .pin_valid     (pin_hint_valid),
        .pin_code      (pin_hint),
        .eff_hint      (eff_hint)
    );

    ddc_defer_fifo #(
        .DEPTH (DEPTH),
        .W     (TAG_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (req_tag),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    ddc_grant_arbiter #(
        .TAG_W (TAG_W)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .eff_hint     (eff_hint),
        .req_valid    (req_valid),
        .req_urgent   (req_urgent),
        .req_tag      (req_tag),
        .req_ready    (req_ready),
        .q_empty      (q_empty),
        .q_full       (q_full),
        .q_head       (q_head),
        .q_push       (q_push),
        .q_pop        (q_pop),
        .grant_valid  (grant_valid),
        .grant_tag    (grant_tag),
        .grant_urgent (grant_urgent)
    );

    // R8
    off_means_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable == SRC_OFF) |-> (eff_hint == HINT_ACTIVE));

endmodule

// File: tb/dma_defer_ctrl_test.sv
// Bench: a vector table walked step by step, then directed tests for
// reset, urgent requests during a drain, and reset during deferral.
module dma_defer_ctrl_test;

    typedef struct packed {
        logic [1:0] sup;
        logic [1:0] en;
        logic       mv;
        logic [1:0] mh;
        logic       pv;
        logic [1:0] ph;
        logic       rv;
        logic       ru;
        logic [7:0] tag;
        logic       rdy;
        logic       gv;
        logic [7:0] gtag;
        logic       gu;
        logic [3:0] rq;
    } vec_t;

    // Fields: sup en mv mh pv ph rv ru tag | rdy gv gtag gu | requirement
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h10, 1'b1,1'b1,8'h10,1'b0,4'd2}, // R2 direct
        '{2'b11,2'b01,1'b1,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd6}, // R6 idle set
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h21, 1'b1,1'b0,8'h00,1'b0,4'd3}, // R3 hold
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h22, 1'b1,1'b0,8'h00,1'b0,4'd3}, // R3 hold
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b1,8'h80, 1'b1,1'b1,8'h80,1'b1,4'd1}, // R1 urgent idle
        '{2'b11,2'b01,1'b0,2'b00,1'b1,2'b01,1'b1,1'b0,8'h23, 1'b1,1'b0,8'h00,1'b0,4'd7}, // R7 pin ignored
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h24, 1'b1,1'b0,8'h00,1'b0,4'd3}, // R3 fills
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h25, 1'b1,1'b1,8'h21,1'b0,4'd4}, // R4 release
        '{2'b11,2'b01,1'b1,2'b10,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b1,8'h22,1'b0,4'd4}, // R4 full
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h26, 1'b0,1'b1,8'h23,1'b0,4'd5}, // R5 drain
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h26, 1'b0,1'b1,8'h24,1'b0,4'd5}, // R5
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h26, 1'b0,1'b1,8'h25,1'b0,4'd5}, // R5
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h26, 1'b1,1'b1,8'h26,1'b0,4'd2}, // R2 after drain
        '{2'b11,2'b01,1'b1,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd6}, // R6 idle
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h30, 1'b1,1'b0,8'h00,1'b0,4'd3}, // R3
        '{2'b11,2'b01,1'b1,2'b01,1'b0,2'b00,1'b1,1'b1,8'h81, 1'b1,1'b1,8'h81,1'b1,4'd1}, // R1
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b1,8'h30,1'b0,4'd5}, // R5 active
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd5}, // R5 empty
        '{2'b11,2'b01,1'b1,2'b11,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd6}, // R6 reserved
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h31, 1'b1,1'b1,8'h31,1'b0,4'd6}, // R6 still active
        '{2'b11,2'b01,1'b1,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd6}, // R6 idle
        '{2'b11,2'b00,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h32, 1'b1,1'b1,8'h32,1'b0,4'd8}, // R8 off
        '{2'b11,2'b01,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h33, 1'b1,1'b1,8'h33,1'b0,4'd8}, // R8 restored
        '{2'b01,2'b10,1'b0,2'b00,1'b1,2'b00,1'b1,1'b0,8'h34, 1'b1,1'b1,8'h34,1'b0,4'd8}, // R8 unsupported
        '{2'b11,2'b10,1'b0,2'b00,1'b1,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd7}, // R7 pin idle
        '{2'b11,2'b10,1'b0,2'b00,1'b0,2'b00,1'b1,1'b0,8'h35, 1'b1,1'b0,8'h00,1'b0,4'd7}, // R7 held
        '{2'b11,2'b10,1'b1,2'b01,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd7}, // R7 msg ignored
        '{2'b11,2'b10,1'b0,2'b00,1'b1,2'b01,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd7}, // R7 pin active
        '{2'b11,2'b10,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b1,8'h35,1'b0,4'd5}, // R5 release
        '{2'b11,2'b10,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00,1'b0,4'd5}  // R5 empty
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cap_supported = 2'b11;
    logic [1:0] ctl_enable = 2'b01;
    logic       msg_hint_valid = 1'b0;
    logic [1:0] msg_hint = 2'b01;
    logic       pin_hint_valid = 1'b0;
    logic [1:0] pin_hint = 2'b01;
    logic       req_valid = 1'b0;
    logic       req_urgent = 1'b0;
    logic [7:0] req_tag = 8'h00;
    logic       req_ready;
    logic       grant_valid;
    logic [7:0] grant_tag;
    logic       grant_urgent;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_defer_ctrl #(.DEPTH(4), .TAG_W(8)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap_supported  (cap_supported),
        .ctl_enable     (ctl_enable),
        .msg_hint_valid (msg_hint_valid),
        .msg_hint       (msg_hint),
        .pin_hint_valid (pin_hint_valid),
        .pin_hint       (pin_hint),
        .req_valid      (req_valid),
        .req_urgent     (req_urgent),
        .req_tag        (req_tag),
        .req_ready      (req_ready),
        .grant_valid    (grant_valid),
        .grant_tag      (grant_tag),
        .grant_urgent   (grant_urgent)
    );

    // Drive one vector, check ready before the edge and the grant after it
    task automatic run(input vec_t v, input int idx);
        @(negedge clk);
        cap_supported  = v.sup;
        ctl_enable     = v.en;
        msg_hint_valid = v.mv;
        msg_hint       = v.mh;
        pin_hint_valid = v.pv;
        pin_hint       = v.ph;
        req_valid      = v.rv;
        req_urgent     = v.ru;
        req_tag        = v.tag;
        #2;
        if (v.rv) begin
            checks++;
            if (req_ready !== v.rdy) begin
                failures++;
                $display("FAIL R%0d step %0d ready actual=%b expected=%b",
                         v.rq, idx, req_ready, v.rdy);
            end
        end
        @(posedge clk);
        #2;
        checks++;
        if (grant_valid !== v.gv ||
            (v.gv && (grant_tag !== v.gtag || grant_urgent !== v.gu))) begin
            failures++;
            $display("FAIL R%0d step %0d grant actual v=%b tag=%h u=%b expected v=%b tag=%h u=%b",
                     v.rq, idx, grant_valid, grant_tag, grant_urgent, v.gv, v.gtag, v.gu);
        end
    endtask

    function automatic vec_t mk(input logic [1:0] en, input logic mv, input logic [1:0] mh,
                                input logic rv, input logic ru, input logic [7:0] tag,
                                input logic rdy, input logic gv, input logic [7:0] gtag,
                                input logic gu, input logic [3:0] rq);
        mk = '{2'b11, en, mv, mh, 1'b0, 2'b00, rv, ru, tag, rdy, gv, gtag, gu, rq};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9: grant quiet while reset is held
        checks++;
        if (grant_valid !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset grant actual=%b expected=0", grant_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run(VEC[i], i);

        // R1 urgent request in the middle of a drain of a full store
        run(mk(2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd6), 100);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h50, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 101);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h51, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 102);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h52, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 103);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h53, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 104);
        run(mk(2'b01, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h50, 1'b0, 4'd4), 105);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b1, 8'h90, 1'b1, 1'b1, 8'h90, 1'b1, 4'd1), 106);
        run(mk(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h51, 1'b0, 4'd5), 107);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h60, 1'b0, 1'b1, 8'h52, 1'b0, 4'd5), 108);
        run(mk(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h53, 1'b0, 4'd5), 109);
        run(mk(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd5), 110);

        // R9 reset while entries are deferred: store and hint must clear
        run(mk(2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd6), 111);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h40, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 112);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h41, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3), 113);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        checks++;
        if (grant_valid !== 1'b0) begin
            failures++;
            $display("FAIL R9 mid reset grant actual=%b expected=0", grant_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        run(mk(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd9), 114);
        run(mk(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd9), 115);
        run(mk(2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 8'h42, 1'b1, 1'b1, 8'h42, 1'b0, 4'd9), 116);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule